// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer with separate write and read clocks. Words are pushed on the write clock while the write enable is low and popped on the read clock while the read enable is low. An output enable turns the read data bus on or off. The block reports a full and an empty condition, a more-than-half-full condition, and two level warnings, almost-empty and almost-full. Each level warning compares against a threshold that software can change.

The two thresholds sit in small registers. These registers are reached through the normal data buses while a load strobe is held low. A write cycle under the strobe stores a threshold, and a read cycle under the strobe returns one on the output bus. The accesses alternate between the two registers, starting with the almost-empty threshold. A static mode input, taken only while reset is applied, selects one of two modes:
- Standard mode: a word appears on the outputs only after a read cycle, and the status pins act as full and empty.
- Look-ahead mode: the oldest word is presented on its own, and the status pins act as input-ready and output-ready.

Pointers cross between the clocks in Gray code through two-flop synchronizers. Each side's flags therefore see the other side's activity two of its own clock edges late. The depth is a power of two set by a parameter, 256 words by default.

Top module: `sfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and until the first access after it rises, the buffer is empty. In standard mode this reads as `wr_stat`=1, `rd_stat`=0, `ae_n`=0, `af_n`=1, `hf_n`=1. Both thresholds are 31, and both access orders point at the almost-empty threshold.
- R2: A write edge with `wen_n`=0 and `ld_n`=1 stores `din` unless the buffer is full. A write while full changes neither the contents nor the order of later reads. The read-side flags see a write after two read-clock edges.
- R3: In standard mode, a read edge with `ren_n`=0, `ld_n`=1 and a non-empty buffer loads the oldest word into the output register. With `ren_n`=1, or when the buffer is empty, the output register keeps its value. The write-side flags see a read after two write-clock edges.
- R4: With `oe_n`=1 the `dout` bus is high impedance. With `oe_n`=0 it drives the output register.
- R5: A write edge with `wen_n`=0 and `ld_n`=0 stores `din[11:0]` into a threshold instead of the buffer. The first such access after reset goes to the almost-empty threshold, the next to the almost-full threshold, and they alternate from then on.
- R6: A read edge with `ren_n`=0 and `ld_n`=0 loads one threshold into the output register and pops nothing. The threshold goes to `dout[11:0]` and `dout[17:12]` are 0. The accesses alternate in the same order as R5, with a separate pointer that reset also clears.
- R7: `ae_n` is 0 exactly when the word count seen by the read side is at or below the almost-empty threshold. In look-ahead mode that count includes a word held valid on the outputs.
- R8: `af_n` is 0 exactly when the number of free locations seen by the write side is at or below the almost-full threshold.
- R9: `hf_n` is 0 exactly when the read-side word count is above half the depth.
- R10: In look-ahead mode, `rd_stat`=0 means a valid word is on the output register. That word is loaded without any read enable. Each read edge with `ren_n`=0 replaces it with the next word, or sets `rd_stat`=1 when nothing is left. A readback under R6 also sets `rd_stat`=1.
- R11: In look-ahead mode, `wr_stat`=0 means the buffer has room. It is 1 when the buffer is full, and the output register then holds one word beyond the depth.
- R12: `fwft_sel` is taken only while reset is applied, where 1 selects look-ahead mode. Changing it later has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwft_sel | input | 1 | Mode select, 1 = look-ahead, taken during reset |
| wen_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Threshold access strobe, active low |
| din | input | 18 | Write data / threshold value in bits 11:0 |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 18 | Read data, high impedance when disabled |
| wr_stat | output | 1 | Standard: 0 = full; look-ahead: 0 = room available |
| rd_stat | output | 1 | Standard: 0 = empty; look-ahead: 0 = output valid |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | More than half full, active low |

## Verification
Both clocks are tied to one source, so a behavioural queue model can follow the two-edge synchronizer delay exactly and compare every output on every edge.

The stimulus covers several patterns, each aimed at a different fault:
- A short burst against programmed small thresholds tells the almost-empty compare apart from an off-by-one.
- A long burst past the depth separates real full handling from a wrapping pointer.
- Alternating and interleaved read/write traffic across the half mark exposes wrong synchronizer latency and a wrong half-full boundary.
- The look-ahead runs, a full fill with defaults restored by reset, and a mode input changed after reset show whether the presented word, the extra output slot and the reset-only sampling behave as required.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Which threshold register the next strobe access reaches.
  typedef enum logic {OFS_EMPTY = 1'b0, OFS_FULL = 1'b1} ofs_sel_e;
  // Operating mode chosen during reset.
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_wr_side.sv
module sfifo_wr_side
  import sfifo_pkg::*;
#(
  parameter int AW      = 8,
  parameter int OFFW    = 12,
  parameter int DEF_OFF = 31
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            mode_in,
  input  logic            wen_n,
  input  logic            ld_n,
  input  logic [OFFW-1:0] ofs_in,
  input  logic [AW:0]     rd_gray,
  output logic [AW-1:0]   wr_addr,
  output logic            wr_push,
  output logic [AW:0]     wr_gray,
  output logic [OFFW-1:0] ofs_empty,
  output logic [OFFW-1:0] ofs_full,
  output logic            wr_stat,
  output logic            af_n
);
  localparam int PW = AW + 1;
  localparam int CW = ((PW > OFFW) ? PW : OFFW) + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic            srst_n, run_q;
  fifo_mode_e      mode_q;
  logic [PW-1:0]   bin_q, bin_d, gray_q, gray_d, rs1_q, rs2_q;
  logic [PW-1:0]   occ, free;
  logic            full, ld_hit;
  ofs_sel_e        sel_q, sel_d;
  logic [OFFW-1:0] ofe_q, ofe_d, off_q, off_d;

  sfifo_rst_sync u_rsync (.clk(clk), .arst_n(arst_n), .srst_n(srst_n));

  always_comb begin
    occ     = bin_q - g2b(rs2_q);
    full    = (occ == DEPTH_V);
    free    = DEPTH_V - occ;
    ld_hit  = !wen_n && !ld_n;
    wr_push = !wen_n && ld_n && !full;
    bin_d   = bin_q + PW'(wr_push);
    gray_d  = bin_d ^ (bin_d >> 1);
    sel_d   = sel_q;
    ofe_d   = ofe_q;
    off_d   = off_q;
    if (ld_hit) begin
      if (sel_q == OFS_EMPTY) ofe_d = ofs_in;
      else                    off_d = ofs_in;
      sel_d = (sel_q == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= 1'b0;
      bin_q  <= '0;
      gray_q <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      sel_q  <= OFS_EMPTY;
      ofe_q  <= OFFW'(DEF_OFF);
      off_q  <= OFFW'(DEF_OFF);
    end else begin
      run_q  <= 1'b1;
      bin_q  <= bin_d;
      gray_q <= gray_d;
      rs1_q  <= rd_gray;
      rs2_q  <= rs1_q;
      sel_q  <= sel_d;
      ofe_q  <= ofe_d;
      off_q  <= off_d;
    end
  end

  // Mode register follows the select input only while the domain is held in reset.
  always_ff @(posedge clk) begin
    if (!run_q) mode_q <= fifo_mode_e'(mode_in);
  end

  assign wr_addr   = bin_q[AW-1:0];
  assign wr_gray   = gray_q;
  assign ofs_empty = ofe_q;
  assign ofs_full  = off_q;
  assign wr_stat   = (mode_q == MODE_FWFT) ? full : !full;
  assign af_n      = !(CW'(free) <= CW'(off_q));

  // R2: a blocked write leaves the write pointer where it was
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (full && !wen_n && ld_n) |=> $stable(bin_q));
  // R5: every strobe write moves the access order to the other threshold
  p_ofs_order_r5: assert property (@(posedge clk) disable iff (!srst_n)
    ld_hit |=> (sel_q != $past(sel_q)));
  // R12: mode stays put once the domain runs
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |=> $stable(mode_q));
endmodule

// File: rtl/sfifo_rd_side.sv
module sfifo_rd_side
  import sfifo_pkg::*;
#(
  parameter int DW   = 18,
  parameter int AW   = 8,
  parameter int OFFW = 12
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            mode_in,
  input  logic            ren_n,
  input  logic            ld_n,
  input  logic [AW:0]     wr_gray,
  input  logic [OFFW-1:0] ofs_empty,
  input  logic [OFFW-1:0] ofs_full,
  input  logic [DW-1:0]   ram_q,
  output logic [AW-1:0]   rd_addr,
  output logic [AW:0]     rd_gray,
  output logic [DW-1:0]   dout_reg,
  output logic            rd_stat,
  output logic            ae_n,
  output logic            hf_n
);
  localparam int PW = AW + 1;
  localparam int CW = ((PW > OFFW) ? PW : OFFW) + 1;
  localparam logic [CW-1:0] HALF_V = CW'(1 << (AW - 1));

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          srst_n, run_q;
  fifo_mode_e    mode_q;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, ws1_q, ws2_q, occ_m;
  logic [CW-1:0] words;
  logic          empty_m, ld_hit, pop, valid_q, valid_d;
  ofs_sel_e      sel_q, sel_d;
  logic [DW-1:0] dout_q, dout_d;

  sfifo_rst_sync u_rsync (.clk(clk), .arst_n(arst_n), .srst_n(srst_n));

  always_comb begin
    occ_m   = g2b(ws2_q) - bin_q;
    empty_m = (occ_m == '0);
    ld_hit  = !ren_n && !ld_n;
    if (mode_q == MODE_FWFT) pop = !empty_m && !ld_hit && (!valid_q || !ren_n);
    else                     pop = !empty_m && !ren_n && ld_n;
    bin_d   = bin_q + PW'(pop);
    gray_d  = bin_d ^ (bin_d >> 1);
    sel_d   = sel_q;
    dout_d  = dout_q;
    valid_d = valid_q;
    if (ld_hit) begin
      dout_d  = {{(DW-OFFW){1'b0}}, (sel_q == OFS_EMPTY) ? ofs_empty : ofs_full};
      sel_d   = (sel_q == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
      valid_d = 1'b0;
    end else if (pop) begin
      dout_d  = ram_q;
      valid_d = 1'b1;
    end else if (!ren_n) begin
      valid_d = 1'b0;
    end
    words = CW'(occ_m) + CW'((mode_q == MODE_FWFT) && valid_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q   <= 1'b0;
      bin_q   <= '0;
      gray_q  <= '0;
      ws1_q   <= '0;
      ws2_q   <= '0;
      sel_q   <= OFS_EMPTY;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      ws1_q   <= wr_gray;
      ws2_q   <= ws1_q;
      sel_q   <= sel_d;
      dout_q  <= dout_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!run_q) mode_q <= fifo_mode_e'(mode_in);
  end

  assign rd_addr  = bin_q[AW-1:0];
  assign rd_gray  = gray_q;
  assign dout_reg = dout_q;
  assign rd_stat  = (mode_q == MODE_FWFT) ? !valid_q : !empty_m;
  assign ae_n     = !(words <= CW'(ofs_empty));
  assign hf_n     = !(words > HALF_V);

  // R3: a read on an empty buffer does not move the read pointer
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == MODE_STD && empty_m && !ren_n && ld_n) |=> $stable(bin_q));
  // R3: without a read cycle the standard-mode output register holds
  p_hold_out_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == MODE_STD && ren_n) |=> $stable(dout_q));
  // R10: a presented word stays until a read cycle consumes it
  p_fwft_keep_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == MODE_FWFT && valid_q && ren_n && ld_n) |=> (valid_q && $stable(dout_q)));
  // R7: nothing stored and nothing presented always reads as almost empty
  p_ae_at_empty_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (empty_m && !valid_q) |-> !ae_n);
  // R12: mode stays put once the domain runs
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |=> $stable(mode_q));
endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag #(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int OFFW    = 12,
  parameter int DEF_OFF = 31
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wen_n,
  input  logic          ld_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          wr_stat,
  output logic          rd_stat,
  output logic          ae_n,
  output logic          af_n,
  output logic          hf_n
);
  logic [AW-1:0]   waddr, raddr;
  logic [AW:0]     wgray, rgray;
  logic            push;
  logic [OFFW-1:0] ofe, off;
  logic [DW-1:0]   ram_q, dout_q;

  sfifo_wr_side #(.AW(AW), .OFFW(OFFW), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wclk), .arst_n(rst_n), .mode_in(fwft_sel), .wen_n(wen_n), .ld_n(ld_n),
    .ofs_in(din[OFFW-1:0]), .rd_gray(rgray), .wr_addr(waddr), .wr_push(push),
    .wr_gray(wgray), .ofs_empty(ofe), .ofs_full(off), .wr_stat(wr_stat), .af_n(af_n)
  );

  sfifo_rd_side #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_rd (
    .clk(rclk), .arst_n(rst_n), .mode_in(fwft_sel), .ren_n(ren_n), .ld_n(ld_n),
    .wr_gray(wgray), .ofs_empty(ofe), .ofs_full(off), .ram_q(ram_q),
    .rd_addr(raddr), .rd_gray(rgray), .dout_reg(dout_q), .rd_stat(rd_stat),
    .ae_n(ae_n), .hf_n(hf_n)
  );

  sfifo_store #(.DW(DW), .AW(AW)) u_mem (
    .clk(wclk), .we(push), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(ram_q)
  );

  // R4: output bus released while the enable is high
  assign dout = oe_n ? {DW{1'bz}} : dout_q;
endmodule

// File: tb/sim_sfifo_pflag.sv
`timescale 1ns/1ps
module sim_sfifo_pflag;
  localparam int DW = 18;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, fwft_sel, wen_n, ren_n, ld_n, oe_n;
  logic [DW-1:0] din;
  wire  [DW-1:0] dout;
  logic wr_stat, rd_stat, ae_n, af_n, hf_n;

  sfifo_pflag u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wen_n(wen_n),
    .ld_n(ld_n), .din(din), .ren_n(ren_n), .oe_n(oe_n), .dout(dout),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
  );

  // Reference model state
  int wcnt, rcnt, rs1, rs2, ws1, ws2, m_pae, m_paf;
  bit m_wsel, m_rsel, m_valid, m_mode;
  logic [DW-1:0] m_dout;
  logic [DW-1:0] q[$];

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit done = 1'b0;

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : mdl
    int ow, orc, ope, opf, occw, occm, words, freew;
    bit pop;
    logic [DW-1:0] tmp;
    if (!rst_n) begin
      wcnt = 0; rcnt = 0; rs1 = 0; rs2 = 0; ws1 = 0; ws2 = 0;
      m_pae = 31; m_paf = 31; m_wsel = 0; m_rsel = 0; m_valid = 0;
      m_dout = '0; m_mode = fwft_sel; q.delete();
    end else begin
      ow = wcnt; orc = rcnt; ope = m_pae; opf = m_paf;
      occw = wcnt - rs2; occm = ws2 - rcnt;
      if (!wen_n && !ld_n) begin
        if (!m_wsel) m_pae = int'(din[11:0]); else m_paf = int'(din[11:0]);
        m_wsel = !m_wsel;
      end else if (!wen_n && occw != DEPTH) begin
        q.push_back(din); wcnt++;
      end
      if (!ren_n && !ld_n) begin
        m_dout = DW'(m_rsel ? opf : ope);
        m_rsel = !m_rsel; m_valid = 0;
      end else begin
        pop = (occm != 0) && (m_mode ? (!m_valid || !ren_n) : !ren_n);
        if (pop) begin
          tmp = q.pop_front(); m_dout = tmp; rcnt++; m_valid = 1;
        end else if (!ren_n) m_valid = 0;
      end
      rs2 = rs1; rs1 = orc; ws2 = ws1; ws1 = ow;
    end
    #1;
    if (!done) begin
      occw  = wcnt - rs2; freew = DEPTH - occw;
      occm  = ws2 - rcnt; words = occm + ((m_mode && m_valid) ? 1 : 0);
      chk("wr_stat", DW'(wr_stat), DW'(m_mode ? (occw == DEPTH) : (occw != DEPTH)));
      chk("rd_stat", DW'(rd_stat), DW'(m_mode ? !m_valid : (occm != 0)));
      chk("ae_n",    DW'(ae_n),    DW'(!(words <= m_pae)));
      chk("af_n",    DW'(af_n),    DW'(!(freew <= m_paf)));
      chk("hf_n",    DW'(hf_n),    DW'(!(words > DEPTH/2)));
      if (!oe_n) chk("dout", dout, m_dout);
      else if (m_dout != '0) begin
        compared++;
        if (dout === m_dout) begin
          mismatched++;
          $display("FAIL %s dout released (R4): actual %h expected z", phase, dout);
        end
      end
    end
  end

  task automatic cyc(bit w, bit r, bit l, bit o, logic [DW-1:0] d);
    @(negedge clk);
    wen_n = w; ren_n = r; ld_n = l; oe_n = o; din = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, '0);
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    fwft_sel = mode; rst_n = 0;
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(5);
  endtask

  initial begin
    rst_n = 0; fwft_sel = 0; wen_n = 1; ren_n = 1; ld_n = 1; oe_n = 0; din = '0;
    phase = "R1";
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(6);
    phase = "R5";                                  // thresholds: empty=5, full=10
    cyc(0, 1, 0, 0, 18'h3F005);
    cyc(0, 1, 0, 0, 18'h2A00A);
    idle(3);
    phase = "R6";
    cyc(1, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, '0);
    idle(2);
    phase = "R7";
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, DW'(18'h1000 + i));
    idle(4);
    phase = "R3";
    for (int i = 0; i < 20; i++) cyc(1, i % 2, 1, 0, '0);
    idle(3);
    phase = "R4";
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, DW'(18'h2F0F0 + i));
    idle(3);
    cyc(1, 0, 1, 0, '0);
    cyc(1, 1, 1, 1, '0); cyc(1, 1, 1, 1, '0); cyc(1, 1, 1, 1, '0);
    cyc(1, 1, 1, 0, '0);
    phase = "R2";
    for (int i = 0; i < 270; i++) cyc(0, 1, 1, 0, DW'((i * 7) ^ 18'h2AAAA));
    idle(4);
    phase = "R8";
    for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, '0);
    idle(4);
    phase = "R9";
    for (int i = 0; i < 320; i++) cyc((i % 3) != 0, 0, 1, 0, DW'(18'h15000 + i));
    idle(4);
    phase = "R10";
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, DW'(18'h0BEE0 + i));
    idle(6);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, '0);
    idle(3);
    phase = "R11";
    for (int i = 0; i < 300; i++) cyc(0, 1, 1, 0, DW'(18'h30000 + i * 3));
    idle(4);
    for (int i = 0; i < 60; i++) cyc(i % 2, 0, 1, 0, DW'(18'h00700 + i));
    for (int i = 0; i < 300; i++) cyc(1, 0, 1, 0, '0);
    idle(3);
    phase = "R12";
    @(negedge clk); fwft_sel = 0;
    for (int i = 0; i < 2; i++) cyc(0, 1, 1, 0, DW'(18'h12340 + i));
    idle(5);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, '0);
    idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired in phase %s: actual running expected finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule